// File: doc/BRIEF.md
# LCD Segment Scan and Output Generator

This block is the refresh half of a 64-column LCD segment driver. It takes three timing signals from the common-side driver: a frame marker, a line clock and an AC polarity signal. From these it tracks which display line is being scanned. It then reads that line's pixels out of a page-organized byte RAM and presents one drive-level code per column to the analog output switches.

A 6-bit line counter is loaded from the start-line value at frame start, which gives vertical scrolling. It then advances once per line. After every counter change, a fetch engine reads one RAM byte per internal clock into a staging buffer. It steps aside whenever the MPU port claims the RAM in that cycle.

On the next rising line clock, the staged line moves into the display latch. The latched bits then pass through three stages:
- display on/off gating;
- the column-order strap, which can mirror the columns;
- a polarity-dependent four-level encoder.

Top module: `lcdscan_top`

## Requirements
- R1: After reset the line counter and display latch are zero, so every column outputs an unlit code: `10` when `m`=1 and `11` when `m`=0.
- R2: At each sampled falling edge of `cl` with `frm` low, the line counter advances by one, wrapping from 63 to 0.
- R3: While `frm` is high, the line counter is loaded with `start_line`. This includes a falling `cl` edge that occurs while `frm` is high.
- R4: The display latch, and therefore `seg_level`, changes only at a sampled rising edge of `cl`. It then takes the line fetched for the current counter value.
- R5: With `disp_on` low, every column outputs the unlit code. The latched line is kept and reappears when `disp_on` returns high.
- R6: With `adc`=1, output column k (`seg_level[2k+1:2k]`, k=0..63) shows RAM column address k. With `adc`=0 it shows address 63-k.
- R7: The per-column code is `{~pixel, ~m}`:
  - `00` selects the positive select level;
  - `01` selects the negative select level;
  - `10` selects the positive non-select level;
  - `11` selects the negative non-select level.
- R8: For line z, column c reads byte `ram_addr = {z[5:3], c[5:0]}` and takes bit `z[2:0]` of that byte. Bit 0 is the top line of the page.
- R9: In a cycle where `mpu_access` is high, the scan read is not taken and the same address is presented again. RAM read data is valid on the clock after a taken read. The fetched line is correct under any pattern of such conflicts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm | input | 1 | Frame marker, high during the first line of a frame |
| cl | input | 1 | Line clock (rise latches, fall advances) |
| m | input | 1 | AC polarity of the LCD drive |
| start_line | input | 6 | Display start line loaded at frame start |
| disp_on | input | 1 | Display on/off flag |
| adc | input | 1 | Column-order strap |
| mpu_access | input | 1 | MPU port owns the RAM this cycle |
| ram_rd_en | output | 1 | Scan read request |
| ram_addr | output | 9 | Scan read address {page, column} |
| ram_rdata | input | 8 | RAM byte, valid one clock after a taken read |
| seg_level | output | 128 | Two-bit drive code per column |

## Verification
The line counter moves on the clock edge that first samples `cl` low. The latch moves on the edge that first samples `cl` high. Gating, mirroring and polarity act on `seg_level` without a register, so an output is due one clock after a `cl` rise and at once after a change of `m`, `adc` or `disp_on`.

The bench drives every input on the falling clock edge and samples one falling edge later. Before each `cl` rise it allows a generous margin: 64 taken reads plus the worst-case stalls of the chosen conflict pattern. Just before that rise, it also confirms that the output still shows the previous line.

// File: rtl/lcdscan_pkg.sv
package lcdscan_pkg;

   // Drive-level codes: bit 1 = non-select, bit 0 = negative polarity half
   typedef enum logic [1:0] {
      LVL_SEL_POS  = 2'b00,
      LVL_SEL_NEG  = 2'b01,
      LVL_NSEL_POS = 2'b10,
      LVL_NSEL_NEG = 2'b11
   } lvl_e;

   function automatic lvl_e lvl_encode(input logic pix, input logic pol);
      lvl_e r;
      case ({pix, pol})
         2'b11:   r = LVL_SEL_POS;
         2'b10:   r = LVL_SEL_NEG;
         2'b01:   r = LVL_NSEL_POS;
         default: r = LVL_NSEL_NEG;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/lcdscan_line_ctr.sv
module lcdscan_line_ctr #(
   parameter int LINE_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frm,
   input  logic              cl,
   input  logic [LINE_W-1:0] start_line,
   output logic [LINE_W-1:0] z,
   output logic              new_line,
   output logic              cl_rise
);

   logic cl_q;
   logic cl_fall;
   logic load_now;
   logic [LINE_W-1:0] z_nxt;

   if (LINE_W < 1) begin : g_bad_w
      $error("lcdscan_line_ctr: LINE_W must be at least 1");
   end

   // previous sample of the line clock, no reset so it tracks from power up
   always_ff @(posedge clk) cl_q <= cl;

   assign cl_fall = cl_q & ~cl;
   assign cl_rise = cl & ~cl_q;

   always_comb begin
      z_nxt    = z;
      load_now = 1'b0;
      if (cl_fall) begin
         z_nxt    = frm ? start_line : z + 1'b1;
         load_now = 1'b1;
      end else if (frm && (start_line != z)) begin
         z_nxt    = start_line;
         load_now = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         z        <= '0;
         new_line <= 1'b0;
      end else begin
         z        <= z_nxt;
         new_line <= load_now;
      end
   end

endmodule

// File: rtl/lcdscan_fetch.sv
module lcdscan_fetch #(
   parameter int COLS   = 64,
   parameter int LINE_W = 6,
   parameter int DATA_W = 8,
   localparam int COL_W  = $clog2(COLS),
   localparam int BIT_W  = $clog2(DATA_W),
   localparam int PAGE_W = LINE_W - BIT_W,
   localparam int ADDR_W = PAGE_W + COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINE_W-1:0] z,
   input  logic              new_line,
   input  logic              mpu_access,
   output logic              ram_rd_en,
   output logic [ADDR_W-1:0] ram_addr,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic [COLS-1:0]   line_buf
);

   localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);

   if ((1 << COL_W) != COLS) begin : g_bad_cols
      $error("lcdscan_fetch: COLS must be a power of two");
   end
   if ((1 << BIT_W) != DATA_W) begin : g_bad_data
      $error("lcdscan_fetch: DATA_W must be a power of two");
   end
   if (PAGE_W < 1) begin : g_bad_page
      $error("lcdscan_fetch: LINE_W must exceed log2(DATA_W)");
   end

   logic             active;
   logic [COL_W-1:0] col;
   logic             pend;
   logic [COL_W-1:0] pend_col;
   logic             grant;
   logic [BIT_W-1:0] bit_sel;

   assign ram_rd_en = active & ~new_line;
   assign grant     = ram_rd_en & ~mpu_access;
   assign ram_addr  = {z[LINE_W-1:BIT_W], col};
   assign bit_sel   = z[BIT_W-1:0];

   // request sequencer: one column per granted cycle
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active   <= 1'b0;
         col      <= '0;
         pend     <= 1'b0;
         pend_col <= '0;
      end else if (new_line) begin
         active   <= 1'b1;
         col      <= '0;
         pend     <= 1'b0;
      end else begin
         pend     <= grant;
         pend_col <= col;
         if (grant) begin
            col <= col + 1'b1;
            if (col == COL_LAST) active <= 1'b0;
         end
      end
   end

   // staging buffer: picks the current line's bit out of each returned byte
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_buf <= '0;
      end else if (pend && !new_line) begin
         line_buf[pend_col] <= ram_rdata[bit_sel];
      end
   end

endmodule

// File: rtl/lcdscan_drive.sv
module lcdscan_drive
   import lcdscan_pkg::*;
#(
   parameter int COLS = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cl_rise,
   input  logic [COLS-1:0]   line_buf,
   input  logic              disp_on,
   input  logic              adc,
   input  logic              m,
   output logic [COLS-1:0]   latch_q,
   output logic [2*COLS-1:0] seg_level
);

   if (COLS < 2) begin : g_bad_cols
      $error("lcdscan_drive: COLS must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       latch_q <= '0;
      else if (cl_rise) latch_q <= line_buf;
   end

   for (genvar k = 0; k < COLS; k++) begin : g_col
      logic pix_fwd;
      logic pix_rev;
      logic pix;
      assign pix_fwd = latch_q[k];
      assign pix_rev = latch_q[COLS-1-k];
      assign pix     = disp_on & (adc ? pix_fwd : pix_rev);
      assign seg_level[2*k +: 2] = lvl_encode(pix, m);
   end

endmodule

// File: rtl/lcdscan_top.sv
module lcdscan_top #(
   parameter int COLS   = 64,
   parameter int LINE_W = 6,
   parameter int DATA_W = 8,
   localparam int ADDR_W = LINE_W - $clog2(DATA_W) + $clog2(COLS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frm,
   input  logic              cl,
   input  logic              m,
   input  logic [LINE_W-1:0] start_line,
   input  logic              disp_on,
   input  logic              adc,
   input  logic              mpu_access,
   output logic              ram_rd_en,
   output logic [ADDR_W-1:0] ram_addr,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic [2*COLS-1:0] seg_level
);

   logic [LINE_W-1:0] z_cur;
   logic              new_line;
   logic              cl_rise;
   logic [COLS-1:0]   line_buf;
   logic [COLS-1:0]   latch_q;

   lcdscan_line_ctr #(.LINE_W(LINE_W)) u_lc (
      .clk(clk), .rst_n(rst_n), .frm(frm), .cl(cl),
      .start_line(start_line), .z(z_cur), .new_line(new_line),
      .cl_rise(cl_rise)
   );

   lcdscan_fetch #(.COLS(COLS), .LINE_W(LINE_W), .DATA_W(DATA_W)) u_fetch (
      .clk(clk), .rst_n(rst_n), .z(z_cur), .new_line(new_line),
      .mpu_access(mpu_access), .ram_rd_en(ram_rd_en), .ram_addr(ram_addr),
      .ram_rdata(ram_rdata), .line_buf(line_buf)
   );

   lcdscan_drive #(.COLS(COLS)) u_drive (
      .clk(clk), .rst_n(rst_n), .cl_rise(cl_rise), .line_buf(line_buf),
      .disp_on(disp_on), .adc(adc), .m(m), .latch_q(latch_q),
      .seg_level(seg_level)
   );

endmodule

// File: rtl/lcdscan_chk.sv
module lcdscan_chk #(
   parameter int COLS   = 64,
   parameter int LINE_W = 6,
   parameter int ADDR_W = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frm,
   input logic              cl,
   input logic [LINE_W-1:0] start_line,
   input logic              disp_on,
   input logic              mpu_access,
   input logic              ram_rd_en,
   input logic [ADDR_W-1:0] ram_addr,
   input logic [2*COLS-1:0] seg_level,
   input logic [LINE_W-1:0] z,
   input logic              new_line,
   input logic [COLS-1:0]   latch_q
);

   logic all_unlit;
   always_comb begin
      all_unlit = 1'b1;
      for (int k = 0; k < COLS; k++) all_unlit &= seg_level[2*k+1];
   end

   AST_LINE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cl) && !frm) |=> (z == $past(z) + 1'b1)); // R2

   AST_FRAME_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
      frm |=> (z == $past(start_line))); // R3

   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(cl) |=> $stable(latch_q)); // R4

   AST_OFF_UNLIT: assert property (@(posedge clk) disable iff (!rst_n)
      !disp_on |-> all_unlit); // R5

   AST_MPU_YIELD: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_rd_en && mpu_access) |=> (new_line || (ram_addr == $past(ram_addr)))); // R9

endmodule

bind lcdscan_top lcdscan_chk #(.COLS(COLS), .LINE_W(LINE_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .frm(frm), .cl(cl), .start_line(start_line),
   .disp_on(disp_on), .mpu_access(mpu_access), .ram_rd_en(ram_rd_en),
   .ram_addr(ram_addr), .seg_level(seg_level), .z(z_cur),
   .new_line(new_line), .latch_q(latch_q)
);

// File: tb/lcdscan_tb.sv
module lcdscan_top_tb_top;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         frm = 1'b0;
   logic         cl = 1'b1;
   logic         m = 1'b1;
   logic [5:0]   start_line = '0;
   logic         disp_on = 1'b1;
   logic         adc = 1'b1;
   logic         mpu_access = 1'b0;
   logic         ram_rd_en;
   logic [8:0]   ram_addr;
   logic [7:0]   ram_rdata = '0;
   logic [127:0] seg_level;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 0;

   logic [7:0]  mem [512];
   logic [15:0] lfsr = 16'hACE1;
   int          thr = 0;
   int          z_b = 0;
   int          prev_z = 0;
   bit          prev_blank = 1;
   string       ftag = "";

   always #10 clk = ~clk;

   lcdscan_top dut_i (
      .clk(clk), .rst_n(rst_n), .frm(frm), .cl(cl), .m(m),
      .start_line(start_line), .disp_on(disp_on), .adc(adc),
      .mpu_access(mpu_access), .ram_rd_en(ram_rd_en), .ram_addr(ram_addr),
      .ram_rdata(ram_rdata), .seg_level(seg_level)
   );

   // RAM model: byte valid one clock after the address
   always @(posedge clk) ram_rdata <= mem[ram_addr];

   // conflict generator
   always @(negedge clk) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mpu_access = (int'(lfsr[1:0]) < thr);
   end

   function automatic logic [127:0] exp_seg(input int zz, input bit blank,
                                            input bit mm, input bit on, input bit aa);
      logic [127:0] r;
      for (int k = 0; k < 64; k++) begin
         int  c;
         bit  d;
         c = aa ? k : 63 - k;
         d = on && !blank && mem[((zz / 8) * 64) + c][zz % 8];
         r[2*k +: 2] = {~d, ~mm};
      end
      return r;
   endfunction

   task automatic chk(input logic [127:0] exp, input string tag);
      n_vec++;
      if (seg_level !== exp) begin
         n_bad++;
         $display("FAIL %s: seg_level=%h expected=%h", tag, seg_level, exp);
      end
   endtask

   task automatic run_line(input bit first, input int waitc);
      @(negedge clk);
      frm = first;
      cl  = 1'b0;
      z_b = first ? int'(start_line) : (z_b + 1) % 64;
      @(negedge clk);
      frm = 1'b0;
      repeat (waitc) @(negedge clk);
      chk(exp_seg(prev_z, prev_blank, 1, 1, adc), {"R4 hold ", ftag});
      cl = 1'b1;
      @(negedge clk);
      chk(exp_seg(z_b, 0, 1, 1, adc), first ? {"R3 R8 preset ", ftag} : {"R2 R8 line ", ftag});
      m = 1'b0;
      @(negedge clk);
      chk(exp_seg(z_b, 0, 0, 1, adc), {"R7 polarity ", ftag});
      m = 1'b1;
      prev_z = z_b;
      prev_blank = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      for (int a = 0; a < 512; a++) mem[a] = 8'((a / 64) * 37 + (a % 64) * 11 + 5 + ((a * a) >> 3));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk({64{2'b10}}, "R1 reset m=1");
      m = 1'b0;
      @(negedge clk);
      chk({64{2'b11}}, "R1 reset m=0");
      m = 1'b1;

      // frame A: start 0, normal order, no conflicts, all 64 lines
      ftag = "A";
      start_line = 6'd0; adc = 1'b1; thr = 0;
      for (int i = 0; i < 64; i++) begin
         run_line(i == 0, 90);
         if (i == 5) begin
            disp_on = 1'b0;
            @(negedge clk);
            chk(exp_seg(prev_z, 0, 1, 0, adc), "R5 display off");
            disp_on = 1'b1;
            @(negedge clk);
            chk(exp_seg(prev_z, 0, 1, 1, adc), "R5 display restored");
         end
      end

      // frame B: scrolled start, mirrored columns, half the cycles lost to the MPU
      ftag = "R6 R9 B";
      start_line = 6'd60; adc = 1'b0; thr = 2;
      @(negedge clk);
      chk(exp_seg(prev_z, 0, 1, 1, 0), "R6 mirror of held line");
      for (int i = 0; i < 66; i++) run_line(i == 0, 220);

      // frame C: odd start, normal order, three in four cycles lost to the MPU
      ftag = "R9 C";
      start_line = 6'd37; adc = 1'b1; thr = 3;
      for (int i = 0; i < 10; i++) run_line(i == 0, 420);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule